// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. In the same cycle it fetches a word from its instruction array, decodes it and reads two source registers. It then computes a result or an address, reads or writes its data array, and chooses the next program counter. All of this settles combinationally. The program counter, the register file and the data array change only at the clock edge that closes the cycle.

The core runs eight instructions. Four are register-to-register operations (add, subtract, AND, OR), and a fifth is a signed set-on-less-than. The other three are a word load, a word store and a branch-if-equal. One decoder table, keyed on the instruction class, drives every mux select and every storage enable. The branch decision comes from the zero flag of an ALU subtract.

The surrounding test environment holds the core in reset while it preloads both memory arrays through write ports. It then releases reset and watches progress through a register probe port, a data-word probe port and the program counter output.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next value of `pcOut` is 0 and every register reads 0. The core makes no register or data-array write while `rst` is high.
- R2: An instruction with opcode 0x00 (bits 31..26) writes to register rd (bits 15..11) the result of rs (bits 25..21) combined with rt (bits 20..16). The function code in bits 5..0 selects the operation: 0x20 add, 0x22 subtract (rs minus rt), 0x24 AND, 0x25 OR.
- R3: Opcode 0x00 with function code 0x2A writes 1 to rd when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R4: Opcode 0x23 (load) writes to rt the data word at byte address rs plus the sign-extended 16-bit immediate (bits 15..0). Negative offsets are included.
- R5: Opcode 0x2B (store) writes rt to the data word at byte address rs plus the sign-extended immediate, and writes no register.
- R6: For opcode 0x04 (branch), when rs equals rt the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4. The branch writes no register and no data word.
- R7: Register 0 always reads 0, and writes aimed at it have no effect.
- R8: Any opcode other than 0x00, 0x23, 0x2B and 0x04 writes no register and no data word, and advances the PC by 4. The same holds for opcode 0x00 with an unlisted function code.
- R9: An instruction that reads and writes the same register uses the old value as its operand. The new value is visible only after the clock edge that ends the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imemWe | input | 1 | Write strobe for preloading the instruction array |
| imemAddr | input | IAW | Word index for an instruction-array preload |
| imemWdata | input | 32 | Instruction word to preload |
| dmemLoadWe | input | 1 | Write strobe for preloading the data array; wins over a store in the same cycle |
| dmemLoadAddr | input | DAW | Word index for a data-array preload |
| dmemLoadData | input | DATA_W | Data word to preload |
| dbgRegSel | input | RAW | Register number shown on `dbgRegData` |
| dbgRegData | output | DATA_W | Combinational view of the selected register |
| dbgMemAddr | input | DAW | Word index shown on `dbgMemData` |
| dbgMemData | output | DATA_W | Combinational view of the selected data word |
| pcOut | output | 32 | Current program counter (byte address) |

## Verification
The two functions that meet in one cycle are a register read and a register write to the same register. This happens when an instruction names its destination as one of its own sources, as in an add of a register to itself into that same register. The bench places such an instruction in the loaded program and points the register probe at the shared register. The probe must show the old value while the PC sits on that instruction, and the doubled value from the next cycle on. The final register contents then confirm that the operand was the old value and not a value already updated within the cycle.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  // Primary opcode values (instruction bits 31..26)
  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  // Function codes for the register class (instruction bits 5..0)
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } aluOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic   regDst;    // 1: destination is rd, 0: rt
    logic   regWrite;  // register file write enable
    logic   aluSrc;    // 1: second operand is the immediate
    logic   memRead;   // data array read enable
    logic   memWrite;  // data array write enable
    logic   memToReg;  // 1: write back the data word
    logic   branch;    // branch instruction: take if zero
    aluOp_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  aluOp_e fnOp;
  logic   fnKnown;

  // ALU-control decoder for the register class
  always_comb begin
    fnKnown = 1'b1;
    fnOp    = ALU_ADD;
    unique case (funct)
      FN_ADD:  fnOp = ALU_ADD;
      FN_SUB:  fnOp = ALU_SUB;
      FN_AND:  fnOp = ALU_AND;
      FN_OR:   fnOp = ALU_OR;
      FN_SLT:  fnOp = ALU_SLT;
      default: fnKnown = 1'b0;
    endcase
  end

  // Main decoder: one row per instruction class
  always_comb begin
    ctrl       = '0;
    ctrl.aluOp = ALU_ADD;
    case (opcode)
      OPC_REG: begin
        ctrl.regDst   = 1'b1;
        ctrl.regWrite = fnKnown;
        ctrl.aluOp    = fnOp;
      end
      OPC_LOAD: begin
        ctrl.regWrite = 1'b1;
        ctrl.aluSrc   = 1'b1;
        ctrl.memRead  = 1'b1;
        ctrl.memToReg = 1'b1;
      end
      OPC_STORE: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluOp_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              zero
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  localparam int RAW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RAW-1:0]    wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [RAW-1:0]    rAddrA,
  input  logic [RAW-1:0]    rAddrB,
  input  logic [RAW-1:0]    rAddrC,
  output logic [DATA_W-1:0] rDataA,
  output logic [DATA_W-1:0] rDataB,
  output logic [DATA_W-1:0] rDataC
);

  logic [DATA_W-1:0] regQ [NREG];

  assign regQ[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                           regQ[i] <= '0;
      else if (we && wAddr == RAW'(i))   regQ[i] <= wData;
    end
  end

  assign rDataA = regQ[rAddrA];
  assign rDataB = regQ[rAddrB];
  assign rDataC = regQ[rAddrC];

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_core_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NREG       = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int RAW = $clog2(NREG),
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic              imemWe,
  input  logic [IAW-1:0]    imemAddr,
  input  logic [31:0]       imemWdata,
  input  logic              dmemLoadWe,
  input  logic [DAW-1:0]    dmemLoadAddr,
  input  logic [DATA_W-1:0] dmemLoadData,
  input  logic [RAW-1:0]    dbgRegSel,
  output logic [DATA_W-1:0] dbgRegData,
  input  logic [DAW-1:0]    dbgMemAddr,
  output logic [DATA_W-1:0] dbgMemData,
  output logic [31:0]       instr,
  output logic [31:0]       pc,
  output logic              takeBranch
);

  logic [31:0]       imem [IMEM_WORDS];
  logic [DATA_W-1:0] dmem [DMEM_WORDS];

  logic [31:0]       pcPlus4, branchTarget, pcNext;
  logic [DATA_W-1:0] immExt, rsData, rtData, aluB, aluY, memRdata, wbData;
  logic [RAW-1:0]    wAddr;
  logic              aluZero;

  // Fetch
  always_ff @(posedge clk) begin
    if (imemWe) imem[imemAddr] <= imemWdata;
  end
  assign instr = imem[pc[IAW+1:2]];

  // Operand selection
  assign immExt = {{(DATA_W-16){instr[15]}}, instr[15:0]};
  assign aluB   = ctrl.aluSrc ? immExt : rtData;
  assign wAddr  = ctrl.regDst ? instr[15:11] : instr[20:16];

  sc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) regs_i (
    .clk    (clk),
    .rst    (rst),
    .we     (ctrl.regWrite && !rst),
    .wAddr  (wAddr),
    .wData  (wbData),
    .rAddrA (instr[25:21]),
    .rAddrB (instr[20:16]),
    .rAddrC (dbgRegSel),
    .rDataA (rsData),
    .rDataB (rtData),
    .rDataC (dbgRegData)
  );

  sc_alu #(.DATA_W(DATA_W)) alu_i (
    .op   (ctrl.aluOp),
    .a    (rsData),
    .b    (aluB),
    .y    (aluY),
    .zero (aluZero)
  );

  // Data array: preload port wins over a store
  always_ff @(posedge clk) begin
    if (dmemLoadWe)                 dmem[dmemLoadAddr]  <= dmemLoadData;
    else if (ctrl.memWrite && !rst) dmem[aluY[DAW+1:2]] <= rtData;
  end
  assign memRdata   = ctrl.memRead ? dmem[aluY[DAW+1:2]] : '0;
  assign dbgMemData = dmem[dbgMemAddr];
  assign wbData     = ctrl.memToReg ? memRdata : aluY;

  // Next PC
  assign pcPlus4      = pc + 32'd4;
  assign branchTarget = pcPlus4 + {immExt[29:0], 2'b00};
  assign takeBranch   = ctrl.branch && aluZero;
  assign pcNext       = takeBranch ? branchTarget : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NREG       = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int RAW = $clog2(NREG),
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              imemWe,
  input  logic [IAW-1:0]    imemAddr,
  input  logic [31:0]       imemWdata,
  input  logic              dmemLoadWe,
  input  logic [DAW-1:0]    dmemLoadAddr,
  input  logic [DATA_W-1:0] dmemLoadData,
  input  logic [RAW-1:0]    dbgRegSel,
  output logic [DATA_W-1:0] dbgRegData,
  input  logic [DAW-1:0]    dbgMemAddr,
  output logic [DATA_W-1:0] dbgMemData,
  output logic [31:0]       pcOut
);

  ctrl_t       ctrlBus;
  logic [31:0] instr;
  logic        takeBranch;

  sc_control ctrl_i (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrlBus)
  );

  sc_datapath #(
    .DATA_W(DATA_W), .NREG(NREG),
    .IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)
  ) dp_i (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrlBus),
    .imemWe       (imemWe),
    .imemAddr     (imemAddr),
    .imemWdata    (imemWdata),
    .dmemLoadWe   (dmemLoadWe),
    .dmemLoadAddr (dmemLoadAddr),
    .dmemLoadData (dmemLoadData),
    .dbgRegSel    (dbgRegSel),
    .dbgRegData   (dbgRegData),
    .dbgMemAddr   (dbgMemAddr),
    .dbgMemData   (dbgMemData),
    .instr        (instr),
    .pc           (pcOut),
    .takeBranch   (takeBranch)
  );

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RAW    = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       pcOut,
  input logic [31:0]       instr,
  input ctrl_t             ctrlBus,
  input logic              takeBranch,
  input logic [RAW-1:0]    dbgRegSel,
  input logic [DATA_W-1:0] dbgRegData
);

  logic [31:0] brOffset;
  logic        knownOpc;
  assign brOffset = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign knownOpc = (instr[31:26] == OPC_REG)   || (instr[31:26] == OPC_LOAD) ||
                    (instr[31:26] == OPC_STORE) || (instr[31:26] == OPC_BEQ);

  AST_PC_RESET: assert property (@(posedge clk)
    rst |=> (pcOut == 32'd0)); // R1

  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !takeBranch |=> (pcOut == $past(pcOut) + 32'd4)); // R8

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    takeBranch |=> (pcOut == $past(pcOut + 32'd4 + brOffset))); // R6

  AST_BRANCH_ONLY_BEQ: assert property (@(posedge clk) disable iff (rst)
    takeBranch |-> (instr[31:26] == OPC_BEQ)); // R6

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
    (dbgRegSel == '0) |-> (dbgRegData == '0)); // R7

  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (rst)
    !knownOpc |-> (!ctrlBus.regWrite && !ctrlBus.memWrite)); // R8

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    ctrlBus.memWrite |-> !ctrlBus.regWrite); // R5

endmodule

bind sc_core sc_core_chk #(.DATA_W(DATA_W), .RAW(RAW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .pcOut      (pcOut),
  .instr      (instr),
  .ctrlBus    (ctrlBus),
  .takeBranch (takeBranch),
  .dbgRegSel  (dbgRegSel),
  .dbgRegData (dbgRegData)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

  localparam int IAW = 6;
  localparam int DAW = 6;
  localparam int NPROG = 23;
  localparam int NCHK  = 18;

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // Program, one word per instruction (word index = PC/4)
  localparam logic [31:0] PROG [NPROG] = '{
    encI(6'h23, 0, 1, 16'd0),        // 0  lw r1,0(r0)
    encI(6'h23, 0, 2, 16'd4),        // 1  lw r2,4(r0)
    encI(6'h23, 0, 3, 16'd8),        // 2  lw r3,8(r0)
    encI(6'h23, 0, 4, 16'd12),       // 3  lw r4,12(r0)
    encR(1, 2, 5, 6'h20),            // 4  add r5
    encR(1, 2, 6, 6'h22),            // 5  sub r6
    encR(3, 4, 7, 6'h24),            // 6  and r7
    encR(3, 4, 8, 6'h25),            // 7  or  r8
    encR(2, 1, 9, 6'h2A),            // 8  slt r9 = (-3 < 5)
    encR(1, 2, 10, 6'h2A),           // 9  slt r10 = (5 < -3)
    encR(1, 1, 0, 6'h20),            // 10 add r0 (ignored)
    encI(6'h2B, 0, 6, 16'd16),       // 11 sw r6,16(r0)
    encR(1, 1, 13, 6'h3F),           // 12 unknown funct, rd r13
    encI(6'h23, 0, 11, 16'd16),      // 13 lw r11,16(r0)
    encI(6'h23, 11, 12, 16'hFFFC),   // 14 lw r12,-4(r11)
    encI(6'h3F, 1, 13, 16'h0013),    // 15 unknown opcode
    encI(6'h04, 1, 2, 16'd5),        // 16 beq not taken
    encI(6'h04, 1, 1, 16'd2),        // 17 beq taken -> 20
    encR(1, 1, 14, 6'h20),           // 18 skipped
    encR(1, 1, 14, 6'h20),           // 19 skipped
    encR(1, 1, 15, 6'h20),           // 20 r15 = 10
    encR(15, 15, 15, 6'h20),         // 21 r15 = r15 + r15
    encI(6'h04, 0, 0, 16'hFFFF)      // 22 branch to itself
  };

  typedef struct packed {
    logic [3:0]  req;
    logic        isMem;
    logic [5:0]  idx;
    logic [31:0] val;
  } chk_t;

  localparam chk_t CHK [NCHK] = '{
    '{4'd4, 1'b0, 6'd1,  32'd5},          // R4
    '{4'd4, 1'b0, 6'd2,  32'hFFFFFFFD},   // R4
    '{4'd4, 1'b0, 6'd3,  32'h0F0F00FF},   // R4
    '{4'd4, 1'b0, 6'd4,  32'h00FF0F0F},   // R4
    '{4'd2, 1'b0, 6'd5,  32'd2},          // R2 add
    '{4'd2, 1'b0, 6'd6,  32'd8},          // R2 sub
    '{4'd2, 1'b0, 6'd7,  32'h000F000F},   // R2 and
    '{4'd2, 1'b0, 6'd8,  32'h0FFF0FFF},   // R2 or
    '{4'd3, 1'b0, 6'd9,  32'd1},          // R3 signed less
    '{4'd3, 1'b0, 6'd10, 32'd0},          // R3 not less
    '{4'd7, 1'b0, 6'd0,  32'd0},          // R7
    '{4'd5, 1'b1, 6'd4,  32'd8},          // R5 store landed
    '{4'd4, 1'b0, 6'd11, 32'd8},          // R4 load after store
    '{4'd4, 1'b0, 6'd12, 32'hFFFFFFFD},   // R4 negative offset
    '{4'd8, 1'b0, 6'd13, 32'd0},          // R8 no register write
    '{4'd8, 1'b1, 6'd6,  32'hA5A5A5A5},   // R8 no data write
    '{4'd6, 1'b0, 6'd14, 32'd0},          // R6 skipped by branch
    '{4'd9, 1'b0, 6'd15, 32'd20}          // R9 old operand used
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imemWe = 1'b0;
  logic [IAW-1:0] imemAddr = '0;
  logic [31:0] imemWdata = '0;
  logic        dmemLoadWe = 1'b0;
  logic [DAW-1:0] dmemLoadAddr = '0;
  logic [31:0] dmemLoadData = '0;
  logic [4:0]  dbgRegSel = '0;
  logic [31:0] dbgRegData;
  logic [DAW-1:0] dbgMemAddr = '0;
  logic [31:0] dbgMemData;
  logic [31:0] pcOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst(rst),
    .imemWe(imemWe), .imemAddr(imemAddr), .imemWdata(imemWdata),
    .dmemLoadWe(dmemLoadWe), .dmemLoadAddr(dmemLoadAddr), .dmemLoadData(dmemLoadData),
    .dbgRegSel(dbgRegSel), .dbgRegData(dbgRegData),
    .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData),
    .pcOut(pcOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic loadData(input int idx, input logic [31:0] val);
    @(negedge clk);
    dmemLoadWe = 1'b1; dmemLoadAddr = DAW'(idx); dmemLoadData = val;
    @(negedge clk);
    dmemLoadWe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    logic [31:0] pcExp;
    logic [31:0] pcNxt;
    logic        sawEnd;

    repeat (3) @(negedge clk);
    // R1: reset state
    dbgRegSel = 5'd5;
    #1;
    check("R1 pc in reset", pcOut, 32'd0);
    check("R1 reg in reset", dbgRegData, 32'd0);

    // Preload while held in reset
    for (int i = 0; i < NPROG; i++) begin
      @(negedge clk);
      imemWe = 1'b1; imemAddr = IAW'(i); imemWdata = PROG[i];
    end
    @(negedge clk);
    imemWe = 1'b0;
    loadData(0, 32'd5);
    loadData(1, 32'hFFFFFFFD);
    loadData(2, 32'h0F0F00FF);
    loadData(3, 32'h00FF0F0F);
    loadData(6, 32'hA5A5A5A5);

    // Release reset and trace the PC; probe r15 for R9
    dbgRegSel = 5'd15;
    @(negedge clk);
    rst = 1'b0;
    pcExp  = 32'd0;
    sawEnd = 1'b0;
    for (int c = 0; c < 40; c++) begin
      #1;
      check("R6 pc trace", pcOut, pcExp);
      if (pcExp == 32'd84) check("R9 old value before edge", dbgRegData, 32'd10);
      if (pcExp == 32'd88 && !sawEnd) begin
        check("R9 new value after edge", dbgRegData, 32'd20);
        sawEnd = 1'b1;
      end
      if (pcExp == 32'd68)      pcNxt = 32'd80;
      else if (pcExp == 32'd88) pcNxt = 32'd88;
      else                      pcNxt = pcExp + 32'd4;
      @(negedge clk);
      pcExp = pcNxt;
    end

    // Final state table
    for (int k = 0; k < NCHK; k++) begin
      string tag;
      tag = $sformatf("R%0d table row %0d", CHK[k].req, k);
      if (CHK[k].isMem) begin
        dbgMemAddr = CHK[k].idx;
        #1;
        check(tag, dbgMemData, CHK[k].val);
      end else begin
        dbgRegSel = CHK[k].idx[4:0];
        #1;
        check(tag, dbgRegData, CHK[k].val);
      end
    end

    // R1: reset in mid-run
    dbgRegSel = 5'd15;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check("R1 pc after run reset", pcOut, 32'd0);
    check("R1 reg after run reset", dbgRegData, 32'd0);
    @(negedge clk);
    #1;
    check("R1 pc held in reset", pcOut, 32'd0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule